// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. The address is the segment shifted left by four bits plus the offset, and any carry out of the top bit is dropped. The result therefore wraps around a 1 MB space (00000h to FFFFFh). Each segment value marks the start of a 64 KB window that begins at sixteen times that value. The block applies no protection and no limit check, so every address in the space can be produced.

Four segment registers (code, stack, data and extra) are loaded through a write port. Each request carries an access kind, a flag for accesses based on BP, an optional segment override and an offset. The block uses these to pick the segment register and forms the address. The address and a valid strobe appear on registered outputs one clock after the request. Reset is asynchronous and active-low, and an internal two-flop synchronizer releases it in step with the clock.

Top module: `segaddr_gen`

## Requirements
- R1: For an accepted request, `addr_out` equals (selected segment × 16 + `req_off`) modulo 2^20, and `addr_valid` is high on the clock edge that follows the request. For example, segment 2000h with offset 3000h gives 23000h, and segment 1234h with offset FFFFh gives 2233Fh.
- R2: A carry out of bit 19 is discarded. Segment FFFFh with offset 0010h gives 00000h.
- R3: The fetch kind (`req_kind` = 0) always uses the code segment. The override inputs have no effect on it.
- R4: The stack kind (`req_kind` = 1) always uses the stack segment. The override inputs have no effect on it.
- R5: The data kind (`req_kind` = 2) with no override uses the stack segment when `req_bp` is 1 and the data segment when `req_bp` is 0.
- R6: The data kind with `req_ovr_en` = 1 uses the segment named by `req_ovr_seg` in place of the default, whatever the value of `req_bp`.
- R7: The string destination kind (`req_kind` = 3) always uses the extra segment. The override inputs have no effect on it.
- R8: Segment ids are encoded 0 = extra, 1 = code, 2 = stack, 3 = data, and both `wr_sel` and `req_ovr_seg` use this encoding. A write with `wr_en` high loads `wr_data` into the segment named by `wr_sel`. Requests from the next cycle on see the new value, while a request in the same cycle as the write still uses the old value.
- R9: After reset all four segments read as 0, `addr_valid` is 0 and `addr_out` is 0.
- R10: A cycle with `req_valid` low gives `addr_valid` low on the next edge, and `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| wr_data | input | 16 | Value to load into the segment |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_bp | input | 1 | Data access is based on BP |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_seg | input | 2 | Override segment id |
| req_off | input | 16 | Offset |
| addr_valid | output | 1 | Address valid, one cycle after the request |
| addr_out | output | 20 | Physical address |

## Verification
The bench builds the block with its default parameters: 16-bit segments, a shift of 4 and a 20-bit address. With these values the worked addresses can be checked exactly, including the wrap at segment FFFFh. Random segment loads and requests cover every pairing of access kind, BP flag and override. Directed steps cover a write and a request in the same cycle, and idle cycles that must hold the last address.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

  localparam int NUM_SEGS = 4;
  localparam int SEG_ID_W = 2;

  typedef enum logic [SEG_ID_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/segaddr_regfile.sv
module segaddr_regfile
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEG_ID_W-1:0] wr_sel,
  input  logic [SEG_W-1:0]    wr_data,
  input  logic [SEG_ID_W-1:0] rd_sel,
  output logic [SEG_W-1:0]    rd_data
);

  logic [SEG_W-1:0] seg_q [NUM_SEGS];

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    logic             ld_en;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      ld_en = wr_en && (wr_sel == SEG_ID_W'(i));
      seg_d = ld_en ? wr_data : seg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[i] <= '0;
      end else begin
        seg_q[i] <= seg_d;
      end
    end

    // R8: a write lands in the named register on the next edge
    assert_seg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEG_ID_W'(i)) |=> (seg_q[i] == $past(wr_data)));
  end

  assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/segaddr_select.sv
module segaddr_select
  import segaddr_pkg::*;
(
  input  logic [1:0]          kind,
  input  logic                bp_based,
  input  logic                ovr_en,
  input  logic [SEG_ID_W-1:0] ovr_seg,
  output logic [SEG_ID_W-1:0] sel
);

  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH:  sel = SEG_CODE;
      ACC_STACK:  sel = SEG_STACK;
      ACC_STRDST: sel = SEG_EXTRA;
      ACC_DATA: begin
        if (ovr_en)        sel = ovr_seg;
        else if (bp_based) sel = SEG_STACK;
        else               sel = SEG_DATA;
      end
      default:    sel = SEG_DATA;
    endcase
  end

endmodule

// File: rtl/segaddr_adder.sv
module segaddr_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAD_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    base    = {seg, {SHIFT{1'b0}}};
    off_ext = {{PAD_W{1'b0}}, off};
    addr    = base + off_ext;
  end

endmodule

// File: rtl/segaddr_gen.sv
module segaddr_gen
  import segaddr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [SEG_W-1:0]          wr_data,
  input  logic                      req_valid,
  input  logic [1:0]                req_kind,
  input  logic                      req_bp,
  input  logic                      req_ovr_en,
  input  logic [1:0]                req_ovr_seg,
  input  logic [OFF_W-1:0]          req_off,
  output logic                      addr_valid,
  output logic [SEG_W+SHIFT-1:0]    addr_out
);

  localparam int ADDR_W = SEG_W + SHIFT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ok = rst_sync_q[1];

  logic [SEG_ID_W-1:0] sel_id;
  logic [SEG_W-1:0]    seg_val;
  logic [ADDR_W-1:0]   sum;

  segaddr_select u_select (
    .kind     (req_kind),
    .bp_based (req_bp),
    .ovr_en   (req_ovr_en),
    .ovr_seg  (req_ovr_seg),
    .sel      (sel_id)
  );

  segaddr_regfile #(.SEG_W(SEG_W)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_ok),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (sel_id),
    .rd_data (seg_val)
  );

  segaddr_adder #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .ADDR_W (ADDR_W)
  ) u_adder (
    .seg  (seg_val),
    .off  (req_off),
    .addr (sum)
  );

  // output stage: next state, then register
  logic              out_en;
  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;

  always_comb begin
    out_en  = req_valid;
    valid_d = req_valid;
    addr_d  = out_en ? sum : addr_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign addr_valid = valid_q;
  assign addr_out   = addr_q;

  // selection rules
  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_kind == ACC_FETCH) |-> (sel_id == SEG_CODE));
  assert_stack_seg_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_kind == ACC_STACK) |-> (sel_id == SEG_STACK));
  assert_ovr_data_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_kind == ACC_DATA && req_ovr_en) |-> (sel_id == req_ovr_seg));
  assert_strdst_extra_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_kind == ACC_STRDST) |-> (sel_id == SEG_EXTRA));

  // output timing
  assert_valid_next_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> addr_valid);
  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    req_valid |=> (addr_out[SHIFT-1:0] == $past(req_off[SHIFT-1:0])));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_valid |=> (!addr_valid && $stable(addr_out)));

endmodule

// File: tb/segaddr_gen_bench.sv
module segaddr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        req_bp;
  logic        req_ovr_en;
  logic [1:0]  req_ovr_seg;
  logic [15:0] req_off;
  logic        addr_valid;
  logic [19:0] addr_out;

  always #10 clk = ~clk;

  segaddr_gen u_segaddr_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_bp      (req_bp),
    .req_ovr_en  (req_ovr_en),
    .req_ovr_seg (req_ovr_seg),
    .req_off     (req_off),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [15:0] model_seg [4];
  logic [19:0] exp_addr;
  logic        exp_valid;

  task automatic chk(input bit ok, input string tag, input logic [19:0] act,
                     input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic v, input logic [1:0] k, input logic bp,
                      input logic oe, input logic [1:0] os, input logic [15:0] off,
                      input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input string tag);
    int s;
    req_valid = v; req_kind = k; req_bp = bp; req_ovr_en = oe;
    req_ovr_seg = os; req_off = off; wr_en = we; wr_sel = ws; wr_data = wd;
    if (v) begin
      case (k)
        2'd0: s = 1;
        2'd1: s = 2;
        2'd3: s = 0;
        default: s = oe ? int'(os) : (bp ? 2 : 3);
      endcase
      exp_addr  = {model_seg[s], 4'h0} + {4'h0, off};
      exp_valid = 1'b1;
    end else begin
      exp_valid = 1'b0;
    end
    if (we) model_seg[ws] = wd;
    @(posedge clk);
    @(negedge clk);
    chk(addr_valid == exp_valid, {tag, " valid"}, {19'd0, addr_valid}, {19'd0, exp_valid});
    chk(addr_out == exp_addr, {tag, " addr"}, addr_out, exp_addr);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%05h expected=%05h", 20'd0, 20'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; req_valid = 0;
    req_kind = 0; req_bp = 0; req_ovr_en = 0; req_ovr_seg = 0; req_off = 0;
    for (int i = 0; i < 4; i++) model_seg[i] = 16'h0;
    exp_addr = 20'h0; exp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state at the ports
    chk(addr_valid == 1'b0, "R9 valid", {19'd0, addr_valid}, 20'd0);
    chk(addr_out == 20'h0, "R9 addr", addr_out, 20'h0);
    step(1, 0, 0, 0, 0, 16'h0005, 0, 0, 0, "R9 code seg zero");
    step(1, 3, 0, 0, 0, 16'h0007, 0, 0, 0, "R9 extra seg zero");

    // R8: loads; a same-cycle request sees the old value
    step(1, 0, 0, 0, 0, 16'h3000, 1, 2'd1, 16'h2000, "R8 same-cycle old value");
    step(1, 0, 0, 0, 0, 16'h3000, 0, 0, 0, "R1 2000:3000");
    step(0, 0, 0, 0, 0, 16'h0, 1, 2'd3, 16'h1234, "R10 idle hold");
    step(0, 0, 0, 0, 0, 16'h0, 1, 2'd2, 16'hAB00, "R10 idle hold");
    step(1, 2, 0, 0, 0, 16'hFFFF, 0, 0, 0, "R1 1234:FFFF");
    step(1, 2, 1, 0, 0, 16'h0010, 1, 2'd0, 16'hFFFF, "R5 bp-based stack");
    step(1, 3, 0, 0, 0, 16'h0010, 0, 0, 0, "R2 wrap FFFF:0010");
    step(1, 3, 0, 0, 0, 16'h0025, 0, 0, 0, "R2 wrap FFFF:0025");
    step(1, 2, 1, 1, 2'd1, 16'h0001, 0, 0, 0, "R6 override beats bp");
    step(1, 0, 0, 1, 2'd3, 16'h0002, 0, 0, 0, "R3 fetch ignores override");
    step(1, 1, 0, 1, 2'd3, 16'h0003, 0, 0, 0, "R4 stack ignores override");
    step(1, 3, 0, 1, 2'd3, 16'h0004, 0, 0, 0, "R7 strdst ignores override");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] k;
      logic       oe;
      string      tag;
      k  = 2'($urandom);
      oe = 1'($urandom);
      case (k)
        2'd0: tag = "R3 fetch";
        2'd1: tag = "R4 stack";
        2'd3: tag = "R7 strdst";
        default: tag = oe ? "R6 override" : "R5 data";
      endcase
      if ($urandom % 5 == 0) tag = "R10 idle";
      step(tag != "R10 idle", k, 1'($urandom), oe, 2'($urandom),
           16'($urandom), 1'($urandom), 2'($urandom), 16'($urandom), tag);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule